// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Multiprocessor Address Filter

This block receives asynchronous serial frames of eleven bits: a low start bit, eight data bits with the least significant bit first, a ninth bit and a high stop bit. The RX line is synchronised and sampled on a strobe that runs at sixteen times the baud rate. A falling edge on the line starts a frame while reception is enabled, and the sixteen-step phase counter restarts on that edge. Each bit is settled by a two-of-three vote over samples 7, 8 and 9 of its sixteen.

When a frame ends, the block decides whether to post it. A bad stop bit raises the frame-error flag and posts nothing. With the multiprocessor filter off, every good frame is posted. With the filter on, only frames whose ninth bit is 1 and whose byte matches the station address are posted. A byte matches in two cases. It may equal the given address at every position where the mask holds a 1. It may also have a 1 at every position where the broadcast pattern (given address OR mask) holds a 1. Other frames are dropped without a trace. A good frame that arrives while an earlier one is still posted and unread raises the overrun flag. An acknowledge pulse clears all three flags.

The state machine has five states. IDLE waits for a falling edge (IDLE to START). START checks the start bit at mid-bit: a high vote is noise (START to IDLE), otherwise the bit runs out (START to DATA). DATA shifts in eight bits (DATA to NINTH after the eighth bit). NINTH captures the ninth bit (NINTH to STOP). STOP votes the stop bit at mid-bit, hands the frame to the flag logic and returns at once (STOP to IDLE), so the next start edge can be caught early.

Top module: `mpuart_rx`

## Requirements
- R1: A frame's eight data bits, least significant bit first, appear on rx_data and its ninth bit on rx_bit9 when rx_done rises. With mp_en at 0, every frame with a good stop bit is posted, whatever its ninth bit.
- R2: A frame is started only by a high-to-low change of the sampled line while rx_en is 1. A frame sent while rx_en is 0 posts nothing.
- R3: Each bit value is the majority of the line samples taken at strobes 7, 8 and 9 after the bit's start, where strobe 0 is the one that detected the falling edge. A single wrong sample at strobe 8 does not change the received value.
- R4: A start bit that votes 1 at mid-bit is noise. The receiver returns to idle and no flag changes.
- R5: A stop bit that votes 0 sets frame_err, leaves rx_done at 0 and leaves rx_data unchanged.
- R6: A frame that would be posted while rx_done is still 1 sets overrun, and rx_data and rx_bit9 keep the unread frame.
- R7: rd_ack held high for one cycle clears rx_done, frame_err and overrun on the next edge. rx_done stays at 1 until then.
- R8: With mp_en at 1, a frame whose ninth bit is 0 is never posted.
- R9: With mp_en at 1 and the ninth bit at 1, a byte a is posted if ((a XOR given_addr) AND addr_mask) is 0.
- R10: With mp_en at 1 and the ninth bit at 1, a byte a is also posted if (a AND b) equals b, with b = given_addr OR addr_mask. Any other byte is dropped and no flag changes.
- R11: After reset, rx_done, frame_err and overrun are 0, and rx_data and rx_bit9 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle strobe at sixteen times the baud rate |
| rx_en | input | 1 | Allows a falling edge to start a frame |
| mp_en | input | 1 | Turns on ninth-bit address filtering |
| given_addr | input | 8 | Station address |
| addr_mask | input | 8 | Address mask, 1 = position compared |
| rd_ack | input | 1 | Pulse that clears the three flags |
| rx_data | output | 8 | Last posted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last posted frame |
| rx_done | output | 1 | A posted frame is waiting |
| frame_err | output | 1 | A stop bit was read as 0 |
| overrun | output | 1 | A frame arrived while rx_done was still 1 |

## Verification
The assertions assume that tick16 is a single-cycle strobe with at least one idle cycle between strobes. They also assume that rd_ack is a pulse of one cycle and that mp_en and the address registers do not change while a frame is being received. The bench raises the strobe for one cycle in every four. It changes rx_in only just after a strobe, so each synchronised sample lines up with a strobe. It sets the configuration inputs only between frames, while the line is idle. The frame-level checks follow from that alignment: each bit lasts exactly sixteen strobes, and a glitch is placed on exactly one chosen strobe.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);

    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= line_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= q[i-1];
        end
    end

    assign line_s = q[STAGES-1];

endmodule

// File: rtl/mprx_filter.sv
module mprx_filter #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] given,
    input  logic [DATA_W-1:0] mask,
    output logic              hit_given,
    output logic              hit_bcast
);

    logic [DATA_W-1:0] bcast;

    always_comb begin
        bcast     = given | mask;
        hit_given = ((addr ^ given) & mask) == '0;
        hit_bcast = (addr & bcast) == bcast;
    end

endmodule

// File: rtl/mprx_fsm.sv
module mprx_fsm
    import mprx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              line_s,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_bit9,
    output logic              frm_stop_ok
);

    localparam int PH_W  = $clog2(OVS);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [PH_W-1:0]  PH_LO   = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OVS/2);
    localparam logic [PH_W-1:0]  PH_HI   = PH_W'(OVS/2 + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

    rx_state_t         state, state_nx;
    logic [PH_W-1:0]   phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              ninth;
    logic              vote_a, vote_b;
    logic              last_s;
    logic              fall, at_mid, at_end, maj;

    always_comb begin
        fall   = tick && rx_en && last_s && !line_s;
        at_mid = tick && (phase == PH_HI);
        at_end = tick && (phase == PH_LAST);
        maj    = (vote_a & vote_b) | (vote_a & line_s) | (vote_b & line_s);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fall) state_nx = ST_START;
            ST_START: begin
                if (at_mid && maj) state_nx = ST_IDLE;
                else if (at_end)   state_nx = ST_DATA;
            end
            ST_DATA:  if (at_end && bit_cnt == BIT_LAST) state_nx = ST_NINTH;
            ST_NINTH: if (at_end) state_nx = ST_STOP;
            ST_STOP:  if (at_mid) state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= '0;
            bit_cnt     <= '0;
            shreg       <= '0;
            ninth       <= 1'b0;
            vote_a      <= 1'b1;
            vote_b      <= 1'b1;
            last_s      <= 1'b1;
            frm_valid   <= 1'b0;
            frm_data    <= '0;
            frm_bit9    <= 1'b0;
            frm_stop_ok <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) last_s <= line_s;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
                phase   <= fall ? PH_W'(1) : '0;
            end else if (tick) begin
                phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                if (phase == PH_LO)  vote_a <= line_s;
                if (phase == PH_MID) vote_b <= line_s;
                if (phase == PH_HI) begin
                    case (state)
                        ST_DATA:  shreg <= {maj, shreg[DATA_W-1:1]};
                        ST_NINTH: ninth <= maj;
                        ST_STOP: begin
                            frm_valid   <= 1'b1;
                            frm_stop_ok <= maj;
                            frm_data    <= shreg;
                            frm_bit9    <= ninth;
                        end
                        default: ;
                    endcase
                end
                if (phase == PH_LAST && state == ST_DATA) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    p_noen_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));

    p_phase_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != ST_IDLE) |=> ($stable(phase) && $stable(state)));

    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    p_noise_back_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && at_mid && maj) |=> (state == ST_IDLE));

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              tick16,
    input  logic              rx_en,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] given_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err,
    output logic              overrun
);

    logic              line_s;
    logic              frm_valid, frm_bit9, frm_stop_ok;
    logic [DATA_W-1:0] frm_data;
    logic              hit_given, hit_bcast;
    logic              accept;

    mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_in),
        .line_s  (line_s)
    );

    mprx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rx_en       (rx_en),
        .line_s      (line_s),
        .frm_valid   (frm_valid),
        .frm_data    (frm_data),
        .frm_bit9    (frm_bit9),
        .frm_stop_ok (frm_stop_ok)
    );

    mprx_filter #(.DATA_W(DATA_W)) u_filter (
        .addr      (frm_data),
        .given     (given_addr),
        .mask      (addr_mask),
        .hit_given (hit_given),
        .hit_bcast (hit_bcast)
    );

    always_comb begin
        accept = frm_stop_ok && (!mp_en || (frm_bit9 && (hit_given || hit_bcast)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (rd_ack) begin
                rx_done   <= 1'b0;
                frame_err <= 1'b0;
                overrun   <= 1'b0;
            end
            if (frm_valid) begin
                if (!frm_stop_ok) begin
                    frame_err <= 1'b1;
                end else if (accept) begin
                    if (rx_done && !rd_ack) begin
                        overrun <= 1'b1;
                    end else begin
                        rx_data <= frm_data;
                        rx_bit9 <= frm_bit9;
                        rx_done <= 1'b1;
                    end
                end
            end
        end
    end

    p_done_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rd_ack) |=> rx_done);

    p_unread_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rd_ack) |=> ($stable(rx_data) && $stable(rx_bit9)));

    p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_done));

    p_mp_needs_bit9_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(mp_en)) |-> rx_bit9);

    p_ferr_no_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_stop_ok && !rx_done) |=> !rx_done);

endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b0;
    logic       mp_en = 1'b0;
    logic [7:0] given_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_done, frame_err, overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    mpuart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
        .rx_en(rx_en), .mp_en(mp_en), .given_addr(given_addr),
        .addr_mask(addr_mask), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done(rx_done), .frame_err(frame_err),
        .overrun(overrun)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (tick16 !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        rx_in = 1'b1;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    // glitch_bit: frame bit index (0 start .. 10 stop) whose strobe-8 sample is inverted, -1 none
    task automatic send(input logic [7:0] d, input logic b9, input logic stop, input int glitch_bit);
        logic [10:0] bits;
        bits = {stop, b9, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            for (int t = 0; t < 16; t++) begin
                rx_in = (b == glitch_bit && t == 8) ? ~bits[b] : bits[b];
                wait_tick();
            end
        end
        idle_ticks(3);
    endtask

    function automatic bit addr_ok(input logic [7:0] a, input logic [7:0] g, input logic [7:0] m);
        logic [7:0] b;
        b = g | m;
        return (((a ^ g) & m) == 8'h00) || ((a & b) == b);
    endfunction

    task automatic addr_case(input logic [7:0] a, input logic b9, input string req);
        bit exp;
        exp = b9 && addr_ok(a, given_addr, addr_mask);
        send(a, b9, 1'b1, -1);
        check(req, rx_done, exp);
        if (exp) check(req, rx_data, a);
        check(req, frame_err, 0);
        ack();
    endtask

    initial begin
        logic [7:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", rx_done, 0);
        check("R11", frame_err, 0);
        check("R11", overrun, 0);
        check("R11", rx_data, 0);
        check("R11", rx_bit9, 0);
        idle_ticks(4);

        // R2 disabled receiver ignores a frame
        rx_en = 1'b0;
        send(8'h5A, 1'b1, 1'b1, -1);
        check("R2", rx_done, 0);
        check("R2", rx_data, 0);
        rx_en = 1'b1;
        idle_ticks(2);

        // R1 data sweep, filter off, ninth bit alternating
        for (int k = 0; k < 16; k++) begin
            logic [7:0] d;
            d = 8'(k * 53 + 17);
            send(d, k[0], 1'b1, -1);
            check("R1", rx_done, 1);
            check("R1", rx_data, d);
            check("R1", rx_bit9, k[0]);
            ack();
            check("R7", rx_done, 0);
        end

        // R3 single glitch on strobe 8 of data bits and ninth bit
        for (int gb = 1; gb < 10; gb++) begin
            send(8'hC3, 1'b0, 1'b1, gb);
            check("R3", rx_done, 1);
            check("R3", rx_data, 8'hC3);
            check("R3", rx_bit9, 0);
            ack();
        end

        // R4 short low pulse is noise
        held = rx_data;
        rx_in = 1'b0;
        for (int t = 0; t < 5; t++) wait_tick();
        idle_ticks(30);
        check("R4", rx_done, 0);
        check("R4", frame_err, 0);
        check("R4", rx_data, held);

        // R5 bad stop bit
        send(8'h3C, 1'b1, 1'b0, -1);
        check("R5", frame_err, 1);
        check("R5", rx_done, 0);
        check("R5", rx_data, held);
        ack();
        check("R7", frame_err, 0);

        // R6 overrun keeps unread frame
        send(8'h11, 1'b0, 1'b1, -1);
        send(8'h22, 1'b1, 1'b1, -1);
        check("R6", rx_done, 1);
        check("R6", overrun, 1);
        check("R6", rx_data, 8'h11);
        check("R6", rx_bit9, 0);
        ack();
        check("R7", rx_done, 0);
        check("R7", overrun, 0);

        // R8 R9 R10 address filter, first configuration
        mp_en = 1'b1;
        given_addr = 8'hA4;
        addr_mask  = 8'hFA;
        idle_ticks(2);
        addr_case(8'hA0, 1'b1, "R9");
        addr_case(8'hA5, 1'b1, "R9");
        addr_case(8'hA2, 1'b1, "R9");
        addr_case(8'hFE, 1'b1, "R10");
        addr_case(8'hFF, 1'b1, "R10");
        addr_case(8'hA0, 1'b0, "R8");
        addr_case(8'hFF, 1'b0, "R8");
        for (int k = 0; k < 24; k++) addr_case(8'(k * 37 + 5), 1'b1, "R9");

        // second configuration
        given_addr = 8'hA7;
        addr_mask  = 8'hF9;
        idle_ticks(2);
        addr_case(8'hA1, 1'b1, "R9");
        addr_case(8'hA7, 1'b1, "R9");
        addr_case(8'hA0, 1'b1, "R9");
        addr_case(8'hFF, 1'b1, "R10");
        addr_case(8'hFE, 1'b1, "R10");
        for (int k = 0; k < 16; k++) addr_case(8'(k * 29 + 160), 1'b1, "R10");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule